// File: doc/BRIEF.md
# Special Character Match Detector

This block sits behind a serial receiver and watches each character as it is handed over. When a character equals one of a small set of programmable reference characters, it raises a sticky special-character interrupt request and reports which reference slot matched. Which slots take part depends on the framing mode. With wide (9-bit) framing, all slots are compared against the full 9-bit character. With enhanced 8-bit operation, only the two flow-control slots take part. The primary stop-transmission slot is active only while in-band flow control is selected. The second stop-transmission slot has its own enable. A match on the primary slot also gives a one-cycle pulse that the transmit flow-control logic consumes.

The interrupt request stays high until software acknowledges it with a clear strobe, which is normally driven by a status read. A later match while the request is pending replaces the reported slot number. Characters that arrived with a framing error or a break condition are never compared. When neither wide framing nor enhanced mode is selected, the match-interrupt enable has another meaning elsewhere in the receiver, and this block stays silent.

Top module: `spc_char_detect`

## Requirements
- R1: While reset is high and on the first cycle after it, `spc_irq`, `spc_idx` and `xoff_seen` are all 0.
- R2: With `cfg_wide_frame`=1 and `cfg_match_ie`=1, a valid character equal in all 9 bits to any slot sets `spc_irq` on the clock edge that samples `rx_valid`. On that edge `spc_idx` takes the slot number. Slot k occupies bits [9k+8:9k] of `chr_table`.
- R3: When several enabled slots match the same character, `spc_idx` reports the lowest-numbered one.
- R4: With `cfg_match_ie`=0, no character ever sets `spc_irq`, in any mode.
- R5: With `cfg_wide_frame`=0, `cfg_enhanced`=1 and `cfg_flow_mode` nonzero, slot 2 is compared on bits [7:0] only, and bit 8 of the character is ignored. A match sets `spc_irq` with `spc_idx`=2 and drives `xoff_seen` high for exactly the following cycle.
- R6: In enhanced mode, slot 3 is compared on bits [7:0] only when `cfg_alt_xoff_en`=1. Its match sets `spc_irq` with `spc_idx`=3 and never pulses `xoff_seen`.
- R7: In enhanced mode, slots 0 and 1 never match. Slot 2 never matches while `cfg_flow_mode` is 0.
- R8: With `cfg_wide_frame`=0 and `cfg_enhanced`=0, no character sets `spc_irq`.
- R9: Once set, `spc_irq` stays high until a cycle with `irq_clr`=1 and no new match. After that cycle it reads 0. A match in the same cycle as `irq_clr` leaves it set.
- R10: A match while `spc_irq` is already high replaces `spc_idx` with the new slot number. Without a match, `spc_idx` holds its value.
- R11: A character presented with `rx_frame_err`=1 or `rx_break`=1 is not compared and sets nothing.
- R12: Nothing is compared in a cycle where `rx_valid` is 0.
- R13: In wide mode, a character that differs from a slot only in bit 8 does not match that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 9 | Received character, bit 8 used only with wide framing |
| rx_frame_err | input | 1 | Character has a framing error |
| rx_break | input | 1 | Character belongs to a break condition |
| chr_table | input | 36 | Four reference characters, slot k at bits [9k+8:9k] |
| cfg_wide_frame | input | 1 | Wide 9-bit framing selected |
| cfg_enhanced | input | 1 | Enhanced mode selected |
| cfg_flow_mode | input | 4 | In-band flow-control mode, nonzero enables slot 2 |
| cfg_alt_xoff_en | input | 1 | Enables the second stop-transmission slot |
| cfg_match_ie | input | 1 | Special-character interrupt enable |
| irq_clr | input | 1 | Acknowledge strobe that clears the request |
| spc_irq | output | 1 | Sticky special-character interrupt request |
| spc_idx | output | 2 | Slot number of the most recent match |
| xoff_seen | output | 1 | One-cycle pulse after a primary stop-character match |

## Verification
The assertions assume that the mode inputs and the reference table are stable in each cycle that carries a strobe. They also assume that the slot parameters name distinct slots inside the table. The stimulus changes configuration only in cycles where `rx_valid` and `irq_clr` are both low. Each character or acknowledge is driven for exactly one cycle and then returned to idle, so every sampled edge sees a consistent mode. The reference table is loaded once, with one slot duplicated and one slot differing only in bit 8, so the priority and width cases can be reached in any mode.

// File: rtl/spc_pkg.sv
package spc_pkg;
  typedef enum logic [1:0] {
    SPC_OFF  = 2'd0,
    SPC_WIDE = 2'd1,
    SPC_ENH  = 2'd2
  } spc_mode_e;
endpackage

// File: rtl/spc_mode_sel.sv
module spc_mode_sel
  import spc_pkg::*;
#(
  parameter int NUM_CHR    = 4,
  parameter int FLOW_W     = 4,
  parameter int XOFF_SLOT  = 2,
  parameter int XOFF2_SLOT = 3
) (
  input  logic               wide_frame,
  input  logic               enhanced,
  input  logic [FLOW_W-1:0]  flow_mode,
  input  logic               alt_xoff_en,
  input  logic               match_ie,
  output spc_mode_e          mode,
  output logic [NUM_CHR-1:0] slot_en
);
  logic flow_on;

  assign flow_on = |flow_mode;

  always_comb begin
    if (wide_frame)    mode = SPC_WIDE;
    else if (enhanced) mode = SPC_ENH;
    else               mode = SPC_OFF;
  end

  for (genvar g = 0; g < NUM_CHR; g++) begin : g_slot
    if (g == XOFF_SLOT) begin : g_xoff
      assign slot_en[g] = match_ie &&
        ((mode == SPC_WIDE) || ((mode == SPC_ENH) && flow_on));
    end else if (g == XOFF2_SLOT) begin : g_xoff2
      assign slot_en[g] = match_ie &&
        ((mode == SPC_WIDE) || ((mode == SPC_ENH) && alt_xoff_en));
    end else begin : g_plain
      assign slot_en[g] = match_ie && (mode == SPC_WIDE);
    end
  end
endmodule

// File: rtl/spc_cmp_bank.sv
module spc_cmp_bank #(
  parameter int NUM_CHR = 4,
  parameter int CHR_W   = 9
) (
  input  logic [CHR_W-1:0]         rx_char,
  input  logic [NUM_CHR*CHR_W-1:0] table_flat,
  input  logic                     narrow,
  output logic [NUM_CHR-1:0]       hit
);
  localparam int NARROW_W = CHR_W - 1;

  for (genvar g = 0; g < NUM_CHR; g++) begin : g_cmp
    logic [CHR_W-1:0] ref_chr;
    logic             eq_full;
    logic             eq_low;

    assign ref_chr = table_flat[g*CHR_W +: CHR_W];
    assign eq_full = (rx_char == ref_chr);
    assign eq_low  = (rx_char[NARROW_W-1:0] == ref_chr[NARROW_W-1:0]);
    assign hit[g]  = narrow ? eq_low : eq_full;
  end
endmodule

// File: rtl/spc_prio_enc.sv
module spc_prio_enc #(
  parameter int NUM_CHR = 4,
  parameter int IDX_W   = $clog2(NUM_CHR)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CHR-1:0] hit,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  logic [NUM_CHR-1:0] below_mask;

  always_comb begin
    any = |hit;
    idx = '0;
    for (int i = NUM_CHR - 1; i >= 0; i--) begin
      if (hit[i]) idx = IDX_W'(i);
    end
  end

  assign below_mask = (NUM_CHR'(1) << idx) - NUM_CHR'(1);

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
    any |-> (hit[idx] && ((hit & below_mask) == '0))); // R3
endmodule

// File: rtl/spc_irq_hold.sv
module spc_irq_hold #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             set_xoff,
  input  logic             clr,
  output logic             irq,
  output logic [IDX_W-1:0] idx,
  output logic             xoff
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq  <= 1'b0;
      idx  <= '0;
      xoff <= 1'b0;
    end else begin
      xoff <= set && set_xoff;
      if (set) begin
        irq <= 1'b1;
        idx <= set_idx;
      end else if (clr) begin
        irq <= 1'b0;
      end
    end
  end

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq && !set && !clr) |=> irq); // R9
  AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !irq); // R9
  AST_IDX_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !set |=> $stable(idx)); // R10
endmodule

// File: rtl/spc_char_detect.sv
module spc_char_detect
  import spc_pkg::*;
#(
  parameter int CHR_W      = 9,
  parameter int NUM_CHR    = 4,
  parameter int FLOW_W     = 4,
  parameter int XOFF_SLOT  = 2,
  parameter int XOFF2_SLOT = 3,
  localparam int IDX_W     = $clog2(NUM_CHR),
  localparam int TBL_W     = NUM_CHR * CHR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [CHR_W-1:0]  rx_char,
  input  logic              rx_frame_err,
  input  logic              rx_break,
  input  logic [TBL_W-1:0]  chr_table,
  input  logic              cfg_wide_frame,
  input  logic              cfg_enhanced,
  input  logic [FLOW_W-1:0] cfg_flow_mode,
  input  logic              cfg_alt_xoff_en,
  input  logic              cfg_match_ie,
  input  logic              irq_clr,
  output logic              spc_irq,
  output logic [IDX_W-1:0]  spc_idx,
  output logic              xoff_seen
);
  spc_mode_e          mode;
  logic [NUM_CHR-1:0] slot_en;
  logic [NUM_CHR-1:0] raw_hit;
  logic [NUM_CHR-1:0] live_hit;
  logic               char_ok;
  logic               win_any;
  logic [IDX_W-1:0]   win_idx;
  logic               win_xoff;

  spc_mode_sel #(
    .NUM_CHR    (NUM_CHR),
    .FLOW_W     (FLOW_W),
    .XOFF_SLOT  (XOFF_SLOT),
    .XOFF2_SLOT (XOFF2_SLOT)
  ) u_mode (
    .wide_frame  (cfg_wide_frame),
    .enhanced    (cfg_enhanced),
    .flow_mode   (cfg_flow_mode),
    .alt_xoff_en (cfg_alt_xoff_en),
    .match_ie    (cfg_match_ie),
    .mode        (mode),
    .slot_en     (slot_en)
  );

  spc_cmp_bank #(
    .NUM_CHR (NUM_CHR),
    .CHR_W   (CHR_W)
  ) u_cmp (
    .rx_char    (rx_char),
    .table_flat (chr_table),
    .narrow     (mode == SPC_ENH),
    .hit        (raw_hit)
  );

  assign char_ok  = rx_valid && !rx_frame_err && !rx_break;
  assign live_hit = raw_hit & slot_en & {NUM_CHR{char_ok}};

  spc_prio_enc #(
    .NUM_CHR (NUM_CHR),
    .IDX_W   (IDX_W)
  ) u_prio (
    .clk (clk),
    .rst (rst),
    .hit (live_hit),
    .any (win_any),
    .idx (win_idx)
  );

  assign win_xoff = (mode == SPC_ENH) && (win_idx == IDX_W'(XOFF_SLOT));

  spc_irq_hold #(
    .IDX_W (IDX_W)
  ) u_hold (
    .clk      (clk),
    .rst      (rst),
    .set      (win_any),
    .set_idx  (win_idx),
    .set_xoff (win_xoff),
    .clr      (irq_clr),
    .irq      (spc_irq),
    .idx      (spc_idx),
    .xoff     (xoff_seen)
  );

  AST_IE_GATES: assert property (@(posedge clk) disable iff (rst)
    $rose(spc_irq) |-> $past(cfg_match_ie)); // R4
  AST_BAD_CHAR_SKIPPED: assert property (@(posedge clk) disable iff (rst)
    $rose(spc_irq) |-> $past(rx_valid && !rx_frame_err && !rx_break)); // R11
  AST_XOFF_ON_SLOT: assert property (@(posedge clk) disable iff (rst)
    xoff_seen |-> (spc_irq && spc_idx == IDX_W'(XOFF_SLOT))); // R5
  AST_ALT_SILENT: assert property (@(posedge clk) disable iff (rst)
    $rose(spc_irq) |-> $past(cfg_wide_frame || cfg_enhanced)); // R8
endmodule

// File: tb/spc_char_detect_test.sv
`timescale 1ns/1ps
module spc_char_detect_test;
  localparam real HALF = 2.0;

  logic        clk = 1'b0;
  logic        rst;
  logic        rx_valid, rx_frame_err, rx_break, irq_clr;
  logic [8:0]  rx_char;
  logic [8:0]  tbl [4];
  logic [35:0] chr_table;
  logic        cfg_wide_frame, cfg_enhanced, cfg_alt_xoff_en, cfg_match_ie;
  logic [3:0]  cfg_flow_mode;
  logic        spc_irq, xoff_seen;
  logic [1:0]  spc_idx;

  typedef struct {
    logic       irq;
    logic [1:0] idx;
    logic       xoff;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  logic m_irq = 1'b0;
  logic [1:0] m_idx = 2'd0;
  logic m_xoff = 1'b0;

  always #(HALF) clk = ~clk;

  assign chr_table = {tbl[3], tbl[2], tbl[1], tbl[0]};

  spc_char_detect uut (
    .clk (clk), .rst (rst), .rx_valid (rx_valid), .rx_char (rx_char),
    .rx_frame_err (rx_frame_err), .rx_break (rx_break), .chr_table (chr_table),
    .cfg_wide_frame (cfg_wide_frame), .cfg_enhanced (cfg_enhanced),
    .cfg_flow_mode (cfg_flow_mode), .cfg_alt_xoff_en (cfg_alt_xoff_en),
    .cfg_match_ie (cfg_match_ie), .irq_clr (irq_clr),
    .spc_irq (spc_irq), .spc_idx (spc_idx), .xoff_seen (xoff_seen)
  );

  task automatic compare(input exp_t e);
    checks++;
    if (spc_irq !== e.irq || spc_idx !== e.idx || xoff_seen !== e.xoff) begin
      fails++;
      $display("FAIL %s: irq/idx/xoff got %0b/%0d/%0b expected %0b/%0d/%0b",
               e.tag, spc_irq, spc_idx, xoff_seen, e.irq, e.idx, e.xoff);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) compare(q.pop_front());
  end

  task automatic drive(input logic v, input logic [8:0] ch, input logic fe,
                       input logic bk, input logic clr, input string tag);
    logic       found;
    logic [1:0] win;
    @(negedge clk);
    rx_valid = v; rx_char = ch; rx_frame_err = fe; rx_break = bk; irq_clr = clr;
    found = 1'b0;
    win   = 2'd0;
    for (int k = 3; k >= 0; k--) begin
      logic en, eq;
      if (cfg_wide_frame)    en = 1'b1;
      else if (cfg_enhanced) en = (k == 2 && cfg_flow_mode != 4'd0) ||
                                  (k == 3 && cfg_alt_xoff_en);
      else                   en = 1'b0;
      en = en && cfg_match_ie && v && !fe && !bk;
      eq = cfg_wide_frame ? (ch == tbl[k]) : (ch[7:0] == tbl[k][7:0]);
      if (en && eq) begin
        found = 1'b1;
        win   = 2'(k);
      end
    end
    if (found) begin
      m_irq  = 1'b1;
      m_idx  = win;
      m_xoff = !cfg_wide_frame && cfg_enhanced && win == 2'd2;
    end else begin
      m_xoff = 1'b0;
      if (clr) m_irq = 1'b0;
    end
    q.push_back('{m_irq, m_idx, m_xoff, tag});
    @(posedge clk);
    #1;
    rx_valid = 1'b0; irq_clr = 1'b0; rx_frame_err = 1'b0; rx_break = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1;
    rx_valid = 1'b0; rx_char = '0; rx_frame_err = 1'b0; rx_break = 1'b0; irq_clr = 1'b0;
    cfg_wide_frame = 1'b0; cfg_enhanced = 1'b0; cfg_flow_mode = 4'd0;
    cfg_alt_xoff_en = 1'b0; cfg_match_ie = 1'b0;
    tbl[0] = 9'h141; tbl[1] = 9'h042; tbl[2] = 9'h013; tbl[3] = 9'h042;
    repeat (3) @(posedge clk);
    #1;
    compare('{1'b0, 2'd0, 1'b0, "R1 reset"});
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    compare('{1'b0, 2'd0, 1'b0, "R1 after reset"});

    cfg_wide_frame = 1'b1; cfg_match_ie = 1'b1;
    drive(1, 9'h042, 0, 0, 0, "R3 duplicate slots, lowest wins");
    drive(1, 9'h041, 0, 0, 0, "R13 bit 8 differs, index held");
    drive(0, 9'h000, 0, 0, 1, "R9 clear strobe");
    drive(1, 9'h041, 0, 0, 0, "R13 no match on low bits only");
    drive(1, 9'h141, 0, 0, 0, "R2 wide match slot 0");
    drive(1, 9'h013, 0, 0, 0, "R10 overwrite while pending");
    drive(1, 9'h042, 0, 0, 1, "R9 match beats clear");
    drive(0, 9'h000, 0, 0, 1, "R9 clear again");
    drive(0, 9'h013, 0, 0, 0, "R12 no strobe");
    drive(1, 9'h013, 1, 0, 0, "R11 framing error");
    drive(1, 9'h013, 0, 1, 0, "R11 break");
    cfg_match_ie = 1'b0;
    drive(1, 9'h141, 0, 0, 0, "R4 enable off in wide mode");

    cfg_wide_frame = 1'b0; cfg_enhanced = 1'b1; cfg_match_ie = 1'b1;
    cfg_flow_mode = 4'b0010; cfg_alt_xoff_en = 1'b0;
    drive(1, 9'h041, 0, 0, 0, "R7 slot 0 inactive");
    drive(1, 9'h113, 0, 0, 0, "R5 stop char, bit 8 ignored");
    drive(0, 9'h000, 0, 0, 1, "R5 pulse ends, cleared");
    drive(1, 9'h042, 0, 0, 0, "R6 second slot disabled");
    cfg_alt_xoff_en = 1'b1;
    drive(1, 9'h042, 0, 0, 0, "R6 second slot enabled");
    drive(0, 9'h000, 0, 0, 1, "R9 clear");
    cfg_flow_mode = 4'd0;
    drive(1, 9'h013, 0, 0, 0, "R7 flow control off");
    cfg_match_ie = 1'b0; cfg_flow_mode = 4'b1000;
    drive(1, 9'h013, 0, 0, 0, "R4 enable off in enhanced mode");

    cfg_enhanced = 1'b0; cfg_match_ie = 1'b1; cfg_flow_mode = 4'hF;
    drive(1, 9'h013, 0, 0, 0, "R8 alternate mode silent");
    drive(1, 9'h042, 0, 0, 0, "R8 alternate mode silent slot 3");

    repeat (3) @(posedge clk);
    #1;
    summary();
    $finish;
  end
endmodule